// File: doc/BRIEF.md
# Register-Pair Add/Subtract Unit

This combinational unit does the 16-bit arithmetic on register pairs for a small 8-bit processor core. In one evaluation it takes two 16-bit operands, the current 8-bit flag byte and a 2-bit operation select. It returns a 16-bit result and the updated flag byte. The surrounding core chooses which register pairs feed the operands and writes back the result and the flags. Sequencing over several cycles is left to that core.

Three arithmetic operations are provided, plus a pass-through code:

- **Plain add** changes only the carry-related flags and leaves the others as they were.
- **Add with carry** folds in the incoming carry and rebuilds the whole flag byte.
- **Subtract with borrow** also folds in the incoming carry and rebuilds the whole flag byte.

The unit holds no state. It therefore has no states or transitions, only one output path for each select code:

- `OP_ADD`: plain add.
- `OP_ADC`: add with carry.
- `OP_SBC`: subtract with borrow.
- `OP_PASS`: the first operand and the flags go through unchanged.

Flag byte layout (bit: meaning):

| Bit | Meaning |
|-----|---------|
| 7 | sign |
| 6 | zero |
| 5 | spare |
| 4 | half-carry |
| 3 | spare |
| 2 | overflow |
| 1 | subtract marker |
| 0 | carry |

Top module: `pair_arith16`

## Requirements
- R1: `op_sel` selects the operation: 0 is plain add, 1 is add with carry, 2 is subtract with borrow, 3 is pass. With code 3, `result` equals `opa` and `flags_out` equals `flags_in`.
- R2: With plain add, `result` is `opa + opb` modulo 2^16 and flag bit 0 is bit 16 of the sum. The incoming carry (`flags_in` bit 0) has no effect.
- R3: With plain add, flag bits 7, 6, 5, 3 and 2 are copied from `flags_in`, and bit 1 is cleared.
- R4: For all three arithmetic operations, flag bit 4 is bit 12 of `(opa ^ opb ^ result)`. This is the carry or borrow into bit 12.
- R5: With add with carry, `result` is `opa + opb + flags_in[0]` modulo 2^16. Flag bit 0 is bit 16 of that sum, and flag bit 1 is cleared.
- R6: With add with carry and with subtract with borrow, flag bit 7 equals `result[15]` and flag bit 6 is set exactly when `result` is 0. Flag bits 5 and 3 are cleared.
- R7: With add with carry, flag bit 2 is set exactly when both operands have the same bit 15 and `result[15]` differs from it.
- R8: With subtract with borrow, `result` is `opa - opb - flags_in[0]` modulo 2^16. Flag bit 0 is the borrow out of bit 15, and flag bit 1 is set.
- R9: With subtract with borrow, flag bit 2 is set exactly when the operands differ in bit 15 and `result[15]` differs from `opa[15]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code (0 add, 1 add with carry, 2 subtract with borrow, 3 pass) |
| opa | input | 16 | First operand (destination pair) |
| opb | input | 16 | Second operand |
| flags_in | input | 8 | Current flag byte |
| result | output | 16 | 16-bit result |
| flags_out | output | 8 | Updated flag byte |

## Verification
Operand pairs are chosen so that each one separates a single effect:

- **Carry at bit 12 and bit 16.** Some pairs carry exactly into bit 12. Others wrap at bit 16 to a zero result. This shows whether half-carry and carry are taken from the right positions.
- **Sign boundary, both directions.** Some pairs cross 0x7FFF/0x8000 in each direction, so the add-overflow and subtract-overflow rules can be told apart.
- **Incoming carry and preserved bits.** The same shapes are run with the incoming carry set and clear, and with a flag byte that is all ones or all zeros. This shows that plain add ignores the carry and keeps the preserved bits, while the carry forms rebuild the byte.
- **Subtract with borrow.** Vectors that borrow through zero, and one that gives an exact zero, check the borrow flag and the zero flag for subtraction.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADC  = 2'd1,
        OP_SBC  = 2'd2,
        OP_PASS = 2'd3
    } pair_op_e;

    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_X3 = 3;
    localparam int FL_H  = 4;
    localparam int FL_X5 = 5;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;
    localparam int FLAG_W = 8;
endpackage

// File: rtl/pair_addsub.sv
module pair_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcarry,
    output logic         ovf
);
    localparam int HB = W - 4;
    localparam int SB = W - 1;

    logic [W:0] ext;

    always_comb begin
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        sum    = ext[W-1:0];
        cout   = ext[W];
        hcarry = a[HB] ^ b[HB] ^ ext[HB];
        if (sub) begin
            ovf = (a[SB] != b[SB]) && (ext[SB] != a[SB]);
        end else begin
            ovf = (a[SB] == b[SB]) && (ext[SB] != a[SB]);
        end
    end

    // R8: equal operands with no borrow in give zero and no borrow out
    always_comb begin
        if (sub && !cin && (a == b)) begin
            a_r8_equal_zero: assert (sum == '0 && !cout)
                else $error("a_r8_equal_zero");
        end
    end
endmodule

// File: rtl/pair_flag_gen.sv
module pair_flag_gen
    import pair_arith_pkg::*;
#(
    parameter int W = 16
) (
    input  pair_op_e              op,
    input  logic [FLAG_W-1:0]     flags_in,
    input  logic [W-1:0]          sum,
    input  logic                  cout,
    input  logic                  hcarry,
    input  logic                  ovf,
    output logic [FLAG_W-1:0]     flags_out
);
    logic zero_w;

    assign zero_w = (sum == '0);

    always_comb begin
        flags_out = flags_in;
        unique case (op)
            OP_ADD: begin
                flags_out[FL_H] = hcarry;
                flags_out[FL_N] = 1'b0;
                flags_out[FL_C] = cout;
            end
            OP_ADC, OP_SBC: begin
                flags_out        = '0;
                flags_out[FL_S]  = sum[W-1];
                flags_out[FL_Z]  = zero_w;
                flags_out[FL_H]  = hcarry;
                flags_out[FL_PV] = ovf;
                flags_out[FL_N]  = (op == OP_SBC);
                flags_out[FL_C]  = cout;
            end
            OP_PASS: begin
                flags_out = flags_in;
            end
            default: flags_out = flags_in;
        endcase
    end
endmodule

// File: rtl/pair_arith16.sv
module pair_arith16
    import pair_arith_pkg::*;
(
    input  logic [1:0]  op_sel,
    input  logic [15:0] opa,
    input  logic [15:0] opb,
    input  logic [7:0]  flags_in,
    output logic [15:0] result,
    output logic [7:0]  flags_out
);
    localparam int W = 16;

    pair_op_e      op;
    logic          carry_in;
    logic          do_sub;
    logic [W-1:0]  sum_w;
    logic          cout_w;
    logic          hc_w;
    logic          ovf_w;

    assign op       = pair_op_e'(op_sel);
    assign carry_in = (op != OP_ADD) && flags_in[FL_C];
    assign do_sub   = (op == OP_SBC);

    pair_addsub #(.W(W)) core_i (
        .a      (opa),
        .b      (opb),
        .cin    (carry_in),
        .sub    (do_sub),
        .sum    (sum_w),
        .cout   (cout_w),
        .hcarry (hc_w),
        .ovf    (ovf_w)
    );

    pair_flag_gen #(.W(W)) flags_i (
        .op        (op),
        .flags_in  (flags_in),
        .sum       (sum_w),
        .cout      (cout_w),
        .hcarry    (hc_w),
        .ovf       (ovf_w),
        .flags_out (flags_out)
    );

    assign result = (op == OP_PASS) ? opa : sum_w;

    always_comb begin
        if (op == OP_PASS) begin
            a_r1_pass: assert (result == opa && flags_out == flags_in)
                else $error("a_r1_pass");
        end
        if (op == OP_ADD) begin
            a_r2_add_sum: assert ({flags_out[FL_C], result} == ({1'b0, opa} + {1'b0, opb}))
                else $error("a_r2_add_sum");
            a_r3_keep_flags: assert (flags_out[FL_S] == flags_in[FL_S] &&
                                     flags_out[FL_Z] == flags_in[FL_Z] &&
                                     flags_out[FL_PV] == flags_in[FL_PV] &&
                                     !flags_out[FL_N])
                else $error("a_r3_keep_flags");
        end
        if (op == OP_ADC || op == OP_SBC) begin
            a_r6_sign_zero: assert (flags_out[FL_Z] == (result == '0) &&
                                    flags_out[FL_S] == result[W-1] &&
                                    !flags_out[FL_X5] && !flags_out[FL_X3])
                else $error("a_r6_sign_zero");
        end
        if (op == OP_SBC) begin
            a_r8_sbc_diff: assert (flags_out[FL_N] &&
                                   result == (opa - opb - {{(W-1){1'b0}}, flags_in[FL_C]}))
                else $error("a_r8_sbc_diff");
        end
    end
endmodule

// File: tb/pair_arith16_tb_top.sv
module pair_arith16_tb_top;
    logic        clk;
    logic        rst_n;
    logic [1:0]  op_sel;
    logic [15:0] opa;
    logic [15:0] opb;
    logic [7:0]  flags_in;
    logic [15:0] result;
    logic [7:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [7:0]  fi;
        logic [15:0] er;
        logic [7:0]  ef;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 16'h0FFF, 16'h0001, 8'hFF, 16'h1000, 8'hFC}, // R2 R3 R4 carry-in ignored
        '{2'd0, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h11}, // R2 R3 zero kept clear
        '{2'd0, 16'h8000, 16'h8000, 8'h2A, 16'h0000, 8'h29}, // R3 spare kept, N cleared
        '{2'd0, 16'h1234, 16'h4321, 8'h80, 16'h5555, 8'h80}, // R2 R3 no carries
        '{2'd1, 16'h7FFF, 16'h0000, 8'h01, 16'h8000, 8'h94}, // R5 R7 overflow up
        '{2'd1, 16'hFFFF, 16'h0000, 8'h01, 16'h0000, 8'h51}, // R5 R6 zero wrap
        '{2'd1, 16'h1234, 16'h1111, 8'hFE, 16'h2345, 8'h00}, // R6 bits cleared
        '{2'd1, 16'h8000, 16'h8000, 8'h00, 16'h0000, 8'h45}, // R7 negative overflow
        '{2'd2, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h93}, // R8 borrow R4
        '{2'd2, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h16}, // R9 overflow down
        '{2'd2, 16'h1234, 16'h1233, 8'h01, 16'h0000, 8'h42}, // R8 R6 exact zero
        '{2'd2, 16'h0005, 16'h0003, 8'hFF, 16'h0001, 8'h02}, // R8 borrow in, R6 clears
        '{2'd2, 16'h7FFF, 16'hFFFF, 8'h00, 16'h8000, 8'h87}, // R9 overflow up
        '{2'd3, 16'hBEEF, 16'h1234, 8'hA5, 16'hBEEF, 8'hA5}  // R1 pass
    };

    pair_arith16 dut_i (
        .op_sel    (op_sel),
        .opa       (opa),
        .opb       (opb),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s result: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s flags: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y,
                         input logic [7:0] f);
        @(posedge clk);
        op_sel   <= o;
        opa      <= x;
        opb      <= y;
        flags_in <= f;
        @(negedge clk);
    endtask

    initial begin
        rst_n    = 1'b0;
        op_sel   = 2'd3;
        opa      = 16'h0000;
        opb      = 16'h0000;
        flags_in = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, pass code with zero inputs: R1
        check16("R1 reset", result, 16'h0000);
        check8("R1 reset", flags_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].fi);
            check16($sformatf("vec%0d R1-table", i), result, TBL[i].er);
            check8($sformatf("vec%0d R1-table", i), flags_out, TBL[i].ef);
        end

        // R2: plain add gives the same sum with carry in set or clear
        apply(2'd0, 16'h00FF, 16'h0001, 8'h01);
        check16("R2 carry-in ignored", result, 16'h0100);
        // R5: add with carry adds the incoming carry
        apply(2'd1, 16'h00FF, 16'h0001, 8'h01);
        check16("R5 carry-in used", result, 16'h0101);
        check8("R5 flags", flags_out, 8'h00);
        // R4: half-carry from bit 12 on subtract
        apply(2'd2, 16'h1000, 16'h0001, 8'h00);
        check16("R8 result", result, 16'h0FFF);
        check8("R4 half borrow", flags_out, 8'h12);
        // R3: plain add keeps an all-ones preserved set with no carries
        apply(2'd0, 16'h0001, 16'h0001, 8'hEF);
        check8("R3 preserve", flags_out, 8'hEC);
        // R7: differing operand signs never overflow on add with carry
        apply(2'd1, 16'h7FFF, 16'h8000, 8'h01);
        check16("R7 result", result, 16'h0000);
        check8("R7 no overflow", flags_out, 8'h51);
        // R9: same signs never overflow on subtract
        apply(2'd2, 16'h8000, 16'hFFFF, 8'h00);
        check8("R9 no overflow", flags_out, 8'h93);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule